// File: doc/BRIEF.md
# Strobed Overvoltage Fault Filter

This block sits between an output-voltage comparator and the auto-restart supervisor of a switching converter. The comparator says whether the sensed feedback voltage is above its limit. That reading is only meaningful while the power switch is off and after the ringing that follows turn-off has died away. The filter therefore looks at the comparator only inside a short sampling window. The window opens a fixed number of clocks after each turn-off edge and lasts a fixed number of clocks.

Each oscillator cycle in which at least one in-window sample was above the limit counts as a qualifying cycle. Any oscillator cycle without such a sample clears the count. When the count reaches the trip number (four by default), the block raises a one-clock fault pulse. The supervisor uses that pulse to stop switching and start its restart sequence. The count then starts again from zero.

Top module: `ovp_strobe_filter`

## Requirements
- R1: A comparator reading is taken only while `gate_on` is low. If the switch turns back on during the delay or the window, the remaining window is dropped.
- R2: Let E0 be the first rising clock edge at which `gate_on` is sampled low after being high. Only the edges E0+STROBE_DLY through E0+STROBE_DLY+WIN_LEN-1 sample `ov_above`. Readings at earlier or later edges are ignored.
- R3: An oscillator cycle adds at most one to the run count, however many in-window samples are above the limit. A cycle ends at a clock edge with `osc_tick` high.
- R4: An oscillator cycle with no above-limit in-window sample resets the run count to zero.
- R5: `ovp_fault` is high for exactly one clock. It rises in the clock that follows the `osc_tick` edge closing the TRIP-th consecutive qualifying cycle. TRIP defaults to 4.
- R6: The run count is zero after a fault, so the next fault needs TRIP more qualifying cycles.
- R7: Synchronous active-high `rst` clears the run count, the window state and `ovp_fault`.
- R8: An oscillator cycle in which the switch never turns on is clean, whatever `ov_above` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| gate_on | input | 1 | Power switch gate state, 1 = conducting |
| osc_tick | input | 1 | One-clock pulse marking the end of an oscillator cycle |
| ov_above | input | 1 | Comparator output, 1 = sensed voltage above limit |
| ovp_fault | output | 1 | One-clock fault pulse to the restart supervisor |

## Verification
The bench drives each oscillator cycle with a chosen span of above-limit offsets, measured in clocks from the turn-off edge. Spans that fill the whole window separate a single increment per cycle from one per sample. Spans covering only the first or the last window edge, or only the clocks just before or just after the window, pin down where the window sits. Cycles with an early re-turn-on, cycles with no turn-on at all, and a clean cycle or reset inserted into a run show that the count clears and is never resumed. Readings held high during the on-time check that on-time readings are ignored.

// File: rtl/ovf_pkg.sv
package ovf_pkg;
  // Default timing: 2.2 us strobe delay at a 200 MHz system clock.
  localparam int unsigned DEF_STROBE_DLY = 440;
  localparam int unsigned DEF_WIN_LEN    = 8;
  localparam int unsigned DEF_TRIP       = 4;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/ovf_strobe_window.sv
module ovf_strobe_window #(
  parameter int unsigned STROBE_DLY = 440,
  parameter int unsigned WIN_LEN    = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_on,
  input  logic ov_above,
  output logic win_open,
  output logic sample_hit
);
  localparam int unsigned LAST_OFS = STROBE_DLY + WIN_LEN - 1;
  localparam int unsigned EL_W     = ovf_pkg::cnt_width(LAST_OFS);

  logic            gate_d;
  logic            active;
  logic [EL_W-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_d  <= 1'b0;
      active  <= 1'b0;
      elapsed <= '0;
    end else begin
      gate_d <= gate_on;
      if (gate_on) begin
        active <= 1'b0;
      end else if (gate_d) begin
        active  <= 1'b1;
        elapsed <= EL_W'(1);
      end else if (active) begin
        if (elapsed == EL_W'(LAST_OFS)) active <= 1'b0;
        else                            elapsed <= elapsed + 1'b1;
      end
    end
  end

  always_comb begin
    win_open   = active && (elapsed >= EL_W'(STROBE_DLY));
    sample_hit = win_open && !gate_on && ov_above;
  end
endmodule

// File: rtl/ovf_cycle_flag.sv
module ovf_cycle_flag (
  input  logic clk,
  input  logic rst,
  input  logic sample_hit,
  input  logic osc_tick,
  output logic cyc_qual
);
  logic seen;

  always_ff @(posedge clk) begin
    if (rst || osc_tick) seen <= 1'b0;
    else if (sample_hit) seen <= 1'b1;
  end

  assign cyc_qual = seen || sample_hit;
endmodule

// File: rtl/ovf_run_count.sv
module ovf_run_count #(
  parameter int unsigned TRIP  = 4,
  parameter int unsigned RUN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc_tick,
  input  logic             cyc_qual,
  output logic [RUN_W-1:0] run_cnt,
  output logic             fault
);
  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      fault   <= 1'b0;
    end else begin
      fault <= 1'b0;
      if (osc_tick) begin
        if (!cyc_qual) begin
          run_cnt <= '0;
        end else if (run_cnt == RUN_W'(TRIP - 1)) begin
          run_cnt <= '0;
          fault   <= 1'b1;
        end else begin
          run_cnt <= run_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ovp_strobe_filter.sv
module ovp_strobe_filter #(
  parameter int unsigned STROBE_DLY = ovf_pkg::DEF_STROBE_DLY,
  parameter int unsigned WIN_LEN    = ovf_pkg::DEF_WIN_LEN,
  parameter int unsigned TRIP       = ovf_pkg::DEF_TRIP
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_on,
  input  logic osc_tick,
  input  logic ov_above,
  output logic ovp_fault
);
  localparam int unsigned RUN_W = ovf_pkg::cnt_width(TRIP);

  logic             win_w;
  logic             hit_w;
  logic             qual_w;
  logic [RUN_W-1:0] run_w;

  ovf_strobe_window #(.STROBE_DLY(STROBE_DLY), .WIN_LEN(WIN_LEN)) win_i (
    .clk(clk), .rst(rst), .gate_on(gate_on), .ov_above(ov_above),
    .win_open(win_w), .sample_hit(hit_w)
  );

  ovf_cycle_flag flag_i (
    .clk(clk), .rst(rst), .sample_hit(hit_w), .osc_tick(osc_tick),
    .cyc_qual(qual_w)
  );

  ovf_run_count #(.TRIP(TRIP), .RUN_W(RUN_W)) cnt_i (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .cyc_qual(qual_w),
    .run_cnt(run_w), .fault(ovp_fault)
  );
endmodule

// File: rtl/ovp_strobe_filter_chk.sv
module ovp_strobe_filter_chk #(
  parameter int unsigned TRIP  = 4,
  parameter int unsigned RUN_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             gate_on,
  input logic             osc_tick,
  input logic             ovp_fault,
  input logic             win_open,
  input logic             sample_hit,
  input logic             cyc_qual,
  input logic [RUN_W-1:0] run_cnt
);
  p_hit_only_off_r1: assert property (@(posedge clk) disable iff (rst)
    sample_hit |-> (!gate_on && win_open));

  p_count_bounded_r3: assert property (@(posedge clk) disable iff (rst)
    run_cnt < RUN_W'(TRIP));

  p_clean_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (osc_tick && !cyc_qual) |=> (run_cnt == '0));

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    ovp_fault |=> !ovp_fault);

  p_fault_after_tick_r5: assert property (@(posedge clk) disable iff (rst)
    ovp_fault |-> ($past(osc_tick) && $past(cyc_qual)));

  p_cleared_after_fault_r6: assert property (@(posedge clk) disable iff (rst)
    ovp_fault |-> (run_cnt == '0));

  p_reset_clears_r7: assert property (@(posedge clk)
    rst |=> (!ovp_fault && run_cnt == '0));
endmodule

bind ovp_strobe_filter ovp_strobe_filter_chk #(.TRIP(TRIP), .RUN_W(RUN_W)) chk_i (
  .clk(clk), .rst(rst), .gate_on(gate_on), .osc_tick(osc_tick),
  .ovp_fault(ovp_fault), .win_open(win_w), .sample_hit(hit_w),
  .cyc_qual(qual_w), .run_cnt(run_w)
);

// File: tb/ovp_strobe_filter_tb_top.sv
`timescale 1ns/1ps
module ovp_strobe_filter_tb_top;
  localparam int D    = 10;
  localparam int W    = 8;
  localparam int TRIP = 4;
  localparam int T    = D + W + 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic gate_on = 1'b0;
  logic osc_tick = 1'b0;
  logic ov_above = 1'b0;
  logic ovp_fault;

  int total = 0;
  int bad = 0;
  int model_run = 0;
  bit finished = 0;
  logic tick_d = 1'b0;

  bit    exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  ovp_strobe_filter #(.STROBE_DLY(D), .WIN_LEN(W), .TRIP(TRIP)) dut_i (
    .clk(clk), .rst(rst), .gate_on(gate_on), .osc_tick(osc_tick),
    .ov_above(ov_above), .ovp_fault(ovp_fault)
  );

  always @(posedge clk) tick_d <= osc_tick;

  // Monitor: compare at the falling edge after each tick edge; flag stray pulses.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && tick_d) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL R5 unexpected tick result: actual=%0b expected=<none>", ovp_fault);
        end else begin
          bit e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (ovp_fault !== e) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", t, ovp_fault, e);
          end
        end
      end else if (ovp_fault !== 1'b0) begin
        total++;
        bad++;
        $display("FAIL R5 pulse outside tick slot: actual=%0b expected=0", ovp_fault);
      end
    end
  end

  // Driver: one oscillator cycle. Above-limit offsets lo..hi, counted in
  // clocks from the turn-off edge; reon > 0 turns the switch back on at that offset.
  task automatic drive_cycle(input int on_clk, input int lo, input int hi,
                             input int reon, input string tag);
    int  a;
    int  b;
    bit  qual;
    bit  e;
    a = (lo > D) ? lo : D;
    b = (hi < D + W - 1) ? hi : D + W - 1;
    if (reon > 0 && b > reon - 1) b = reon - 1;
    qual = (on_clk > 0) && (a <= b);
    e = 1'b0;
    if (qual) begin
      if (model_run == TRIP - 1) begin e = 1'b1; model_run = 0; end
      else model_run++;
    end else begin
      model_run = 0;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    for (int i = 0; i < on_clk; i++) begin
      @(negedge clk);
      gate_on = 1'b1;
      ov_above = 1'b1;
    end
    for (int k = 0; k <= T; k++) begin
      @(negedge clk);
      gate_on  = (reon > 0 && k >= reon);
      ov_above = (k >= lo && k <= hi);
      osc_tick = (k == T);
    end
    @(negedge clk);
    osc_tick = 1'b0;
    ov_above = 1'b0;
  endtask

  task automatic full(input string tag);
    drive_cycle(6, 0, T, 0, tag);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    total++;
    if (ovp_fault !== 1'b0) begin
      bad++;
      $display("FAIL R7 reset state: actual=%0b expected=0", ovp_fault);
    end
    rst = 1'b0;

    // R3/R5: whole window above limit, fault only on the fourth cycle
    full("R3 full window c1"); full("R3 full window c2");
    full("R3 full window c3"); full("R5 trip on fourth full cycle");

    // R2: ringing before the window is ignored, and it clears the run (R4)
    full("R6 after fault c1"); full("R6 after fault c2"); full("R6 after fault c3");
    drive_cycle(6, 0, D - 1, 0, "R2 ringing before window clean");
    full("R4 restart c1"); full("R4 restart c2");
    full("R4 no fault on third after clear");
    full("R4 fault on fourth after clear");

    // R2: first and last window edges count; the edge just after does not
    drive_cycle(6, D, D, 0, "R2 first window edge");
    drive_cycle(6, D + W - 1, D + W - 1, 0, "R2 last window edge");
    drive_cycle(6, D, D, 0, "R2 first edge again");
    drive_cycle(6, D + W, D + W, 0, "R2 edge after window clean");
    drive_cycle(6, D, D, 0, "R2 edge c1"); drive_cycle(6, D, D, 0, "R2 edge c2");
    drive_cycle(6, D, D, 0, "R2 edge c3");
    drive_cycle(6, D + W - 1, D + W - 1, 0, "R5 fault via last edge");

    // R1: switch turns back on at the window start; in-window readings ignored
    full("R1 pre c1"); full("R1 pre c2"); full("R1 pre c3");
    drive_cycle(6, D, D + W - 1, D, "R1 re-turn-on blocks samples");
    full("R1 post c1"); full("R1 post c2"); full("R1 post c3");
    full("R1 fault after re-turn-on run");

    // R8: no turn-on in the cycle, comparator high throughout
    full("R8 pre c1"); full("R8 pre c2"); full("R8 pre c3");
    drive_cycle(0, 0, T, 0, "R8 idle cycle clean");
    full("R8 post c1"); full("R8 post c2"); full("R8 post c3");
    full("R8 fault after idle clear");

    // R7: reset in the middle of a run
    full("R7 pre c1"); full("R7 pre c2"); full("R7 pre c3");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    model_run = 0;
    full("R7 after reset c1"); full("R7 after reset c2");
    full("R7 after reset c3"); full("R7 fault after reset run");

    repeat (4) @(negedge clk);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R5 results missing: actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end
endmodule